// File: doc/BRIEF.md
# Deflection Control Register Slave with Retrace Commit

This block is the two-wire serial control port of a display deflection controller. It answers to one fixed 7-bit device address. A write selects one of sixteen 8-bit adjustment registers with a subaddress byte, then stores one or more data bytes. The register index steps forward by one after every data byte, so a single burst can reload the whole map. A read returns one status byte. That byte is assembled from eight plain status inputs: lock states, the protection latch, sync polarities and sync-detection flags. The read has no subaddress phase.

Every write lands in a shadow copy. The adjustment outputs that drive the analog sections change only on a vertical retrace strobe. On that strobe all sixteen shadow bytes move to the active outputs together, so the picture never shows a half-applied set of settings. Both bus inputs pass through a synchroniser and a stability filter, which suppresses short spikes. SDA is driven only as an open-drain pull-down request.

Top module: `defl_ctrl_i2c`

## Requirements
- R1: After reset, active register 0 (the drive-enable/duty register) reads 0x00, registers 1 to 15 read 0x40 (mid-scale), and the SDA pull-down is off.
- R2: The slave acknowledges the address byte 0x8C (write) or 0x8D (read) by pulling SDA low for the ninth clock. It does not acknowledge any other address byte. Bytes that follow a foreign address change no register.
- R3: In a write, the byte after the address is the subaddress, and only its low 4 bits pick the register. The next byte is stored in that register and acknowledged.
- R4: Each further data byte in the same transfer goes to the next register index. The index wraps from 15 to 0.
- R5: The active outputs keep their value while writes arrive. On a rising edge of the retrace input, all sixteen written values appear on the outputs at once.
- R6: A read returns the status byte MSB first with bits 7..0 = H locked, V locked, X-ray latched, H polarity negative, V polarity negative, extracted-vsync detected, composite detected, separate vsync detected. After a master ACK the status byte is sent again. After a master NACK the slave goes idle with SDA released.
- R7: A stop condition ends the transfer and releases SDA. A repeated start begins a new address phase, and the subaddress from before it is not reused.
- R8: A pulse on SCL or SDA shorter than FILT_CYC clock cycles has no effect. This covers both a false clock edge and a false start condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release (open drain) |
| retrace_i | input | 1 | Vertical retrace strobe, asynchronous |
| h_locked_i | input | 1 | Horizontal loop locked |
| v_locked_i | input | 1 | Vertical loop locked |
| xray_i | input | 1 | X-ray protection latched |
| h_neg_i | input | 1 | Horizontal sync polarity negative |
| v_neg_i | input | 1 | Vertical sync polarity negative |
| vext_det_i | input | 1 | Vsync extracted from composite detected |
| hv_det_i | input | 1 | Composite sync detected |
| v_det_i | input | 1 | Separate vsync detected |
| ctrl_o | output | 128 | Active registers, register n at bits n*8+7..n*8 |

## Verification
The hardest situation to reach is a write whose data is already in the shadow copy while the outputs must still show the old set. Proving that retrace alone moves them needs a check of all sixteen outputs in the window between the stop condition and the strobe. The bench makes that check after every write burst, then again after the strobe. A second hard case is the spike test. It places sub-threshold pulses in the middle of a data byte: a false SCL rise in a low phase and a false SDA fall in a high phase, which would read as a start. The bench then confirms that the stored byte is intact.

// File: rtl/defl_ctrl_pkg.sv
package defl_ctrl_pkg;

    localparam int NREG = 16;
    localparam int AW   = $clog2(NREG);

    typedef logic [7:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_DATA,
        ST_READ
    } bus_st_e;

    typedef struct packed {
        logic h_locked;
        logic v_locked;
        logic xray;
        logic h_neg;
        logic v_neg;
        logic vext_det;
        logic hv_det;
        logic v_det;
    } status_t;

    function automatic byte_t reg_default(input int idx);
        return (idx == 0) ? 8'h00 : 8'h40;
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_CYC    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   filt_q;
    logic                   sync_msb;

    assign sync_msb = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            if (sync_msb == filt_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_CYC - 1)) begin
                filt_q <= sync_msb;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign line_o = filt_q;

    // R8
    filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_msb == filt_q) |=> $stable(filt_q));

endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import defl_ctrl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h46
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_f,
    input  logic          sda_f,
    input  status_t       status,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output byte_t         wr_data
);
    bus_st_e       st_q;
    logic [3:0]    cnt_q;
    byte_t         sh_q;
    byte_t         tx_q;
    logic [AW-1:0] ptr_q;
    logic          oe_q;
    logic          rd_q;
    logic          scl_d, sda_d;
    logic          wr_en_q;
    logic [AW-1:0] wr_addr_q;
    byte_t         wr_data_q;

    logic start_ev, stop_ev, rise_ev, fall_ev;

    assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;
    assign rise_ev  = scl_f & ~scl_d;
    assign fall_ev  = ~scl_f & scl_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            cnt_q     <= '0;
            sh_q      <= '0;
            tx_q      <= '0;
            ptr_q     <= '0;
            oe_q      <= 1'b0;
            rd_q      <= 1'b0;
            scl_d     <= 1'b1;
            sda_d     <= 1'b1;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            scl_d   <= scl_f;
            sda_d   <= sda_f;
            wr_en_q <= 1'b0;
            if (stop_ev) begin
                st_q  <= ST_IDLE;
                oe_q  <= 1'b0;
                cnt_q <= '0;
            end else if (start_ev) begin
                st_q  <= ST_ADDR;
                oe_q  <= 1'b0;
                cnt_q <= '0;
            end else begin
                case (st_q)
                    ST_ADDR, ST_SUB, ST_DATA: begin
                        if (rise_ev && cnt_q < 4'd8) begin
                            sh_q  <= {sh_q[6:0], sda_f};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (fall_ev && cnt_q == 4'd8) begin
                            cnt_q <= 4'd9;
                            oe_q  <= 1'b1;
                            if (st_q == ST_ADDR) begin
                                if (sh_q[7:1] != DEV_ADDR) begin
                                    st_q  <= ST_IDLE;
                                    oe_q  <= 1'b0;
                                    cnt_q <= '0;
                                end else begin
                                    rd_q <= sh_q[0];
                                end
                            end else if (st_q == ST_SUB) begin
                                ptr_q <= sh_q[AW-1:0];
                            end else begin
                                wr_en_q   <= 1'b1;
                                wr_addr_q <= ptr_q;
                                wr_data_q <= sh_q;
                                ptr_q     <= ptr_q + AW'(1);
                            end
                        end else if (fall_ev && cnt_q == 4'd9) begin
                            oe_q  <= 1'b0;
                            cnt_q <= '0;
                            if (st_q == ST_ADDR) begin
                                if (rd_q) begin
                                    st_q <= ST_READ;
                                    tx_q <= status;
                                    oe_q <= ~status[7];
                                end else begin
                                    st_q <= ST_SUB;
                                end
                            end else begin
                                st_q <= ST_DATA;
                            end
                        end
                    end
                    ST_READ: begin
                        if (rise_ev) begin
                            if (cnt_q < 4'd8) begin
                                cnt_q <= cnt_q + 4'd1;
                            end else if (cnt_q == 4'd8) begin
                                if (sda_f) begin
                                    st_q  <= ST_IDLE;
                                    cnt_q <= '0;
                                end else begin
                                    cnt_q <= 4'd9;
                                end
                            end
                        end else if (fall_ev) begin
                            if (cnt_q == 4'd8) begin
                                oe_q <= 1'b0;
                            end else if (cnt_q == 4'd9) begin
                                tx_q  <= status;
                                oe_q  <= ~status[7];
                                cnt_q <= '0;
                            end else begin
                                tx_q <= {tx_q[6:0], 1'b0};
                                oe_q <= ~tx_q[6];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe  = oe_q;
    assign wr_en   = wr_en_q;
    assign wr_addr = wr_addr_q;
    assign wr_data = wr_data_q;

    // R7
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !oe_q);

    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> !oe_q);

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en_q |-> (ptr_q == wr_addr_q + AW'(1)));

endmodule

// File: rtl/ctrl_shadow_bank.sv
module ctrl_shadow_bank
    import defl_ctrl_pkg::*;
#(
    parameter int RS_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  byte_t            wr_data,
    input  logic             retrace_i,
    output logic [NREG*8-1:0] active_o
);
    logic [NREG-1:0][7:0] shadow_q;
    logic [NREG-1:0][7:0] active_q;
    logic [RS_STAGES:0]   rs_q;
    logic                 commit;

    assign commit = rs_q[RS_STAGES-1] & ~rs_q[RS_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_q <= '0;
            for (int i = 0; i < NREG; i++) begin
                shadow_q[i] <= reg_default(i);
                active_q[i] <= reg_default(i);
            end
        end else begin
            rs_q <= {rs_q[RS_STAGES-1:0], retrace_i};
            if (wr_en) begin
                shadow_q[wr_addr] <= wr_data;
            end
            if (commit) begin
                active_q <= shadow_q;
            end
        end
    end

    assign active_o = active_q;

    // R5
    commit_copy_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active_q == $past(shadow_q)));

    // R5
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active_q));

    // R3
    shadow_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (shadow_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/defl_ctrl_i2c.sv
module defl_ctrl_i2c
    import defl_ctrl_pkg::*;
#(
    parameter int         FILT_CYC    = 10,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h46
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic              retrace_i,
    input  logic              h_locked_i,
    input  logic              v_locked_i,
    input  logic              xray_i,
    input  logic              h_neg_i,
    input  logic              v_neg_i,
    input  logic              vext_det_i,
    input  logic              hv_det_i,
    input  logic              v_det_i,
    output logic [NREG*8-1:0] ctrl_o
);
    logic [1:0]    raw_w;
    logic [1:0]    filt_w;
    status_t       status_w;
    logic          wr_en_w;
    logic [AW-1:0] wr_addr_w;
    byte_t         wr_data_w;

    assign raw_w = {scl_i, sda_i};

    for (genvar gi = 0; gi < 2; gi++) begin : g_filt
        i2c_line_filter #(
            .FILT_CYC    (FILT_CYC),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_filt (
            .clk    (clk),
            .rst    (rst),
            .line_i (raw_w[gi]),
            .line_o (filt_w[gi])
        );
    end

    assign status_w = '{h_locked: h_locked_i, v_locked: v_locked_i, xray: xray_i,
                        h_neg: h_neg_i, v_neg: v_neg_i, vext_det: vext_det_i,
                        hv_det: hv_det_i, v_det: v_det_i};

    i2c_byte_engine #(
        .DEV_ADDR (DEV_ADDR)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .scl_f   (filt_w[1]),
        .sda_f   (filt_w[0]),
        .status  (status_w),
        .sda_oe  (sda_pull_o),
        .wr_en   (wr_en_w),
        .wr_addr (wr_addr_w),
        .wr_data (wr_data_w)
    );

    ctrl_shadow_bank #(
        .RS_STAGES (SYNC_STAGES)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en_w),
        .wr_addr   (wr_addr_w),
        .wr_data   (wr_data_w),
        .retrace_i (retrace_i),
        .active_o  (ctrl_o)
    );

endmodule

// File: tb/test_defl_ctrl_i2c.sv
module test_defl_ctrl_i2c;
    localparam int Q  = 25;
    localparam int WD = 190000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         m_scl = 1'b1;
    logic         m_sda = 1'b1;
    logic         sda_pull;
    logic         sda_line;
    logic         retrace = 1'b0;
    logic [7:0]   stat = 8'h00;
    logic [127:0] ctrl;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [7:0] exp_shadow [16];
    logic [7:0] exp_active [16];

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    defl_ctrl_i2c i_defl_ctrl_i2c (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .retrace_i  (retrace),
        .h_locked_i (stat[7]),
        .v_locked_i (stat[6]),
        .xray_i     (stat[5]),
        .h_neg_i    (stat[4]),
        .v_neg_i    (stat[3]),
        .vext_det_i (stat[2]),
        .hv_det_i   (stat[1]),
        .v_det_i    (stat[0]),
        .ctrl_o     (ctrl)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic master_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_line; tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        send_bit(master_ack ? 1'b0 : 1'b1);
    endtask

    task automatic pulse_retrace();
        retrace = 1'b1; tick(6);
        retrace = 1'b0; tick(8);
        for (int i = 0; i < 16; i++) exp_active[i] = exp_shadow[i];
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 16; i++)
            check(req, int'(ctrl[i*8 +: 8]), int'(exp_active[i]), $sformatf("reg%0d", i));
    endtask

    // write burst: address, subaddress, n data bytes
    task automatic wr_burst(input logic [7:0] sub, input int n, input int seed);
        logic ack;
        logic [3:0] p;
        bus_start();
        send_byte(8'h8C, ack);
        check("R2", int'(ack), 0, "write address ack");
        send_byte(sub, ack);
        check("R3", int'(ack), 0, "subaddress ack");
        p = sub[3:0];
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = 8'((seed + k * 37 + 11) & 255);
            send_byte(d, ack);
            check("R3", int'(ack), 0, "data ack");
            exp_shadow[p] = d;
            p = p + 4'd1;
        end
        bus_stop();
        check("R7", int'(sda_pull), 0, "SDA released after stop");
    endtask

    initial begin
        logic ack;
        logic [7:0] rb;
        for (int i = 0; i < 16; i++) begin
            exp_shadow[i] = (i == 0) ? 8'h00 : 8'h40;
            exp_active[i] = exp_shadow[i];
        end
        tick(10);
        rst = 1'b0;
        tick(5);

        // R1 reset state
        check_all("R1");
        check("R1", int'(sda_pull), 0, "SDA released at reset");

        // R3 R4 R5: full-map burst, outputs held until retrace
        wr_burst(8'h00, 16, 5);
        check_all("R5");
        pulse_retrace();
        check_all("R5");

        // R3: upper subaddress bits ignored
        wr_burst(8'hF5, 1, 100);
        check_all("R5");
        pulse_retrace();
        check_all("R3");

        // R4: wrap from 15 to 0
        wr_burst(8'h0E, 4, 200);
        pulse_retrace();
        check_all("R4");

        // R2: foreign addresses ignored
        for (int a = 0; a < 4; a++) begin
            logic [7:0] adr;
            adr = (a == 0) ? 8'h8E : (a == 1) ? 8'h0C : (a == 2) ? 8'h9C : 8'h8F;
            bus_start();
            send_byte(adr, ack);
            check("R2", int'(ack), 1, $sformatf("nack for 0x%0h", adr));
            send_byte(8'h03, ack);
            send_byte(8'hEE, ack);
            bus_stop();
        end
        pulse_retrace();
        check_all("R2");

        // R7: repeated start needs a fresh address and subaddress
        bus_start();
        send_byte(8'h8C, ack);
        send_byte(8'h07, ack);
        bus_start();
        send_byte(8'h8C, ack);
        check("R7", int'(ack), 0, "address after repeated start");
        send_byte(8'h08, ack);
        send_byte(8'h3C, ack);
        exp_shadow[8] = 8'h3C;
        bus_stop();
        pulse_retrace();
        check_all("R7");

        // R8: spikes inside a data byte
        bus_start();
        send_byte(8'h8C, ack);
        send_byte(8'h0A, ack);
        begin
            logic [7:0] d;
            d = 8'h5A;
            for (int i = 7; i >= 0; i--) begin
                m_sda = d[i];
                if (i == 5) begin
                    tick(5); m_scl = 1'b1; tick(4); m_scl = 1'b0; tick(Q - 9);
                end else begin
                    tick(Q);
                end
                m_scl = 1'b1;
                if (i == 6) begin
                    tick(10); m_sda = 1'b0; tick(4); m_sda = 1'b1; tick(2 * Q - 14);
                end else begin
                    tick(2 * Q);
                end
                m_scl = 1'b0; tick(Q);
            end
            m_sda = 1'b1; tick(Q);
            m_scl = 1'b1; tick(Q);
            ack = sda_line; tick(Q);
            m_scl = 1'b0; tick(Q);
            check("R8", int'(ack), 0, "ack of spiked byte");
            exp_shadow[10] = d;
        end
        bus_stop();
        pulse_retrace();
        check_all("R8");

        // R6: status sweep
        for (int k = 0; k < 10; k++) begin
            stat = (k < 8) ? 8'(1 << k) : ((k == 8) ? 8'hA5 : 8'h5A);
            bus_start();
            send_byte(8'h8D, ack);
            check("R2", int'(ack), 0, "read address ack");
            if (k >= 8) begin
                recv_byte(1'b1, rb);
                check("R6", int'(rb), int'(stat), "status byte first");
            end
            recv_byte(1'b0, rb);
            check("R6", int'(rb), int'(stat), "status byte");
            check("R6", int'(sda_pull), 0, "released after NACK");
            bus_stop();
        end
        check_all("R6");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule